// File: doc/BRIEF.md
# Sticky Break-Source Lock Register

This block is a single memory-mapped control word that routes chip fault indications onto one timer break line. There are five fault sources: a processor lockup indication, a parity error from the main memory, a parity error from the backup memory, the output of a supply-voltage detector and a flash double-bit ECC error. Each source has its own enable bit. Software may set an enable bit at any time, but no software write can clear it; only the synchronous reset does. Once a source is armed it therefore stays armed, and runaway code cannot disarm the safety path.

The same word holds two parity error flags, one per memory. Hardware sets a flag when its memory reports a parity error, whether or not that source is routed to the break line. Software clears a flag by writing one to its bit. The break output is registered. A separate lock output mirrors the supply-detector enable, so the detector's own configuration logic can refuse writes once the lock is set.

Top module: `brk_lock_reg`

## Requirements
- R1: After reset, `rd_data` is 0, `brk_out` is 0 and `pvd_cfg_lock` is 0.
- R2: A write with `wr_en` high sets each lock bit whose `wr_data` bit is 1. The new value reads back on `rd_data` after the clock edge. Lock bit positions: bit 0 processor lockup, bit 1 main-memory parity, bit 2 supply detector, bit 3 flash double-bit ECC, bit 4 backup-memory parity.
- R3: A write of 0 to a lock bit that is already set leaves it set.
- R4: In each cycle, `brk_out` equals the OR, sampled at the previous clock edge, of every fault input whose lock bit was set at that edge. A fault whose lock bit is clear has no effect on `brk_out`.
- R5: `flt_par_bkp` high at a clock edge sets flag bit 7, and `flt_par_main` high sets flag bit 8. This happens whatever the lock bits hold.
- R6: Writing 1 to bit 7 or bit 8 clears that flag. Writing 0 to either leaves it unchanged.
- R7: If a flag's fault input is high in the same cycle that software writes 1 to that flag, the flag ends set.
- R8: Bits 5, 6 and 9 to 31 always read 0, and writes to them have no effect.
- R9: `pvd_cfg_lock` always equals lock bit 2 as seen on `rd_data`.
- R10: Asserting `rst` clears every lock bit, both flags and `brk_out` at the next clock edge, even when they were set before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register contents |
| flt_lockup | input | 1 | Processor lockup indication |
| flt_par_main | input | 1 | Main-memory parity error |
| flt_supply | input | 1 | Supply-voltage detector output |
| flt_ecc2 | input | 1 | Flash double-bit ECC error |
| flt_par_bkp | input | 1 | Backup-memory parity error |
| brk_out | output | 1 | Registered timer break request |
| pvd_cfg_lock | output | 1 | Lock for the supply-detector configuration |

## Verification
The bench writes 0 over lock bits that are already set. A design that decoded the locks as ordinary read/write bits would read back 0 there. It raises a parity fault in the same cycle as a write-one clear; if the clear won that race, the flag would drop and an error would be lost. It drives every fault while its lock bit is clear and again once the bit is set, so it catches a swapped gate or a missing break register: the break would appear in the wrong cycle or from the wrong source. It also writes all ones into the reserved bits and checks that the flags and locks stay put through single-bit writes. This catches a design whose reserved bits read back nonzero, or whose flags are cleared by the wrong bit.

// File: rtl/brk_lock_pkg.sv
package brk_lock_pkg;

    localparam int REG_W  = 32;
    localparam int N_SRC  = 5;
    localparam int N_FLAG = 2;

    // lock bit positions, software visible
    localparam int SRC_LOCKUP   = 0;
    localparam int SRC_PAR_MAIN = 1;
    localparam int SRC_SUPPLY   = 2;
    localparam int SRC_ECC      = 3;
    localparam int SRC_PAR_BKP  = 4;

    // flag bit positions, software visible
    localparam int FLG_BKP_POS  = 7;
    localparam int FLG_MAIN_POS = 8;

    // index of each flag inside the flag vector
    localparam int FLG_IDX_BKP  = 0;
    localparam int FLG_IDX_MAIN = 1;

    typedef logic [N_SRC-1:0]  src_vec_t;
    typedef logic [N_FLAG-1:0] flg_vec_t;
    typedef logic [REG_W-1:0]  word_t;

    typedef struct packed {
        logic lockup;
        logic par_main;
        logic supply;
        logic ecc2;
        logic par_bkp;
    } fault_t;

    function automatic src_vec_t fault_to_vec(input fault_t f);
        src_vec_t v;
        v               = '0;
        v[SRC_LOCKUP]   = f.lockup;
        v[SRC_PAR_MAIN] = f.par_main;
        v[SRC_SUPPLY]   = f.supply;
        v[SRC_ECC]      = f.ecc2;
        v[SRC_PAR_BKP]  = f.par_bkp;
        return v;
    endfunction

    function automatic word_t compose_word(input src_vec_t locks, input flg_vec_t flags);
        word_t w;
        w               = '0;
        w[N_SRC-1:0]    = locks;
        w[FLG_BKP_POS]  = flags[FLG_IDX_BKP];
        w[FLG_MAIN_POS] = flags[FLG_IDX_MAIN];
        return w;
    endfunction

endpackage

// File: rtl/brk_lock_bits.sv
module brk_lock_bits #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_req,
    output logic [N-1:0] lock_q
);

    for (genvar i = 0; i < N; i++) begin : g_lock
        always_ff @(posedge clk) begin
            if (rst) begin
                lock_q[i] <= 1'b0;
            end else if (set_req[i]) begin
                lock_q[i] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/brk_err_flags.sv
module brk_err_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] hw_set,
    input  logic [N-1:0] sw_clr,
    output logic [N-1:0] flag_q
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q[i] <= 1'b0;
            end else if (hw_set[i]) begin
                flag_q[i] <= 1'b1;
            end else if (sw_clr[i]) begin
                flag_q[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/brk_gate.sv
module brk_gate #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] fault,
    input  logic [N-1:0] lock,
    output logic         brk_q
);

    logic [N-1:0] armed;

    always_comb begin
        armed = fault & lock;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_q <= 1'b0;
        end else begin
            brk_q <= |armed;
        end
    end

endmodule

// File: rtl/brk_lock_reg.sv
module brk_lock_reg
    import brk_lock_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             flt_lockup,
    input  logic             flt_par_main,
    input  logic             flt_supply,
    input  logic             flt_ecc2,
    input  logic             flt_par_bkp,
    output logic             brk_out,
    output logic             pvd_cfg_lock
);

    fault_t   faults;
    src_vec_t fault_vec;
    src_vec_t lock_set;
    src_vec_t lock_q;
    flg_vec_t flag_set;
    flg_vec_t flag_clr;
    flg_vec_t flag_q;

    always_comb begin
        faults.lockup   = flt_lockup;
        faults.par_main = flt_par_main;
        faults.supply   = flt_supply;
        faults.ecc2     = flt_ecc2;
        faults.par_bkp  = flt_par_bkp;
        fault_vec       = fault_to_vec(faults);

        lock_set = wr_data[N_SRC-1:0] & {N_SRC{wr_en}};

        flag_set               = '0;
        flag_set[FLG_IDX_BKP]  = flt_par_bkp;
        flag_set[FLG_IDX_MAIN] = flt_par_main;

        flag_clr               = '0;
        flag_clr[FLG_IDX_BKP]  = wr_en & wr_data[FLG_BKP_POS];
        flag_clr[FLG_IDX_MAIN] = wr_en & wr_data[FLG_MAIN_POS];
    end

    brk_lock_bits #(.N(N_SRC)) u_locks (
        .clk     (clk),
        .rst     (rst),
        .set_req (lock_set),
        .lock_q  (lock_q)
    );

    brk_err_flags #(.N(N_FLAG)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .hw_set (flag_set),
        .sw_clr (flag_clr),
        .flag_q (flag_q)
    );

    brk_gate #(.N(N_SRC)) u_gate (
        .clk   (clk),
        .rst   (rst),
        .fault (fault_vec),
        .lock  (lock_q),
        .brk_q (brk_out)
    );

    always_comb begin
        rd_data      = compose_word(lock_q, flag_q);
        pvd_cfg_lock = lock_q[SRC_SUPPLY];
    end

endmodule

// File: rtl/brk_lock_chk.sv
module brk_lock_chk
    import brk_lock_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             flt_lockup,
    input logic             flt_par_main,
    input logic             flt_supply,
    input logic             flt_ecc2,
    input logic             flt_par_bkp,
    input logic             brk_out,
    input logic             pvd_cfg_lock
);

    localparam logic [REG_W-1:0] USED_MASK =
        (REG_W'(1) << FLG_BKP_POS) | (REG_W'(1) << FLG_MAIN_POS) | REG_W'((1 << N_SRC) - 1);

    logic [N_SRC-1:0] flt_vec;
    always_comb begin
        flt_vec = '0;
        flt_vec[SRC_LOCKUP]   = flt_lockup;
        flt_vec[SRC_PAR_MAIN] = flt_par_main;
        flt_vec[SRC_SUPPLY]   = flt_supply;
        flt_vec[SRC_ECC]      = flt_ecc2;
        flt_vec[SRC_PAR_BKP]  = flt_par_bkp;
    end

    // R3: a set lock bit never clears without reset
    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (($past(rd_data[N_SRC-1:0]) & ~rd_data[N_SRC-1:0]) == '0));

    // R4: break follows the armed faults one cycle later
    p_brk_follow_r4: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (brk_out == $past(|(flt_vec & rd_data[N_SRC-1:0]))));

    // R5: main-memory parity error sets its flag
    p_main_flag_set_r5: assert property (@(posedge clk) disable iff (rst)
        flt_par_main |=> rd_data[FLG_MAIN_POS]);

    // R5: backup-memory parity error sets its flag
    p_bkp_flag_set_r5: assert property (@(posedge clk) disable iff (rst)
        flt_par_bkp |=> rd_data[FLG_BKP_POS]);

    // R6: without a clear request or set, the main flag holds
    p_main_flag_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!flt_par_main && !(wr_en && wr_data[FLG_MAIN_POS])) |=> $stable(rd_data[FLG_MAIN_POS]));

    // R8: reserved bits stay zero
    p_reserved_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~USED_MASK) == '0);

    // R9: supply lock output tracks the supply lock bit
    p_supply_lock_r9: assert property (@(posedge clk) disable iff (rst)
        pvd_cfg_lock == rd_data[SRC_SUPPLY]);

endmodule

bind brk_lock_reg brk_lock_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .flt_lockup   (flt_lockup),
    .flt_par_main (flt_par_main),
    .flt_supply   (flt_supply),
    .flt_ecc2     (flt_ecc2),
    .flt_par_bkp  (flt_par_bkp),
    .brk_out      (brk_out),
    .pvd_cfg_lock (pvd_cfg_lock)
);

// File: tb/brk_lock_reg_tb.sv
module brk_lock_reg_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        flt_lockup = 1'b0;
    logic        flt_par_main = 1'b0;
    logic        flt_supply = 1'b0;
    logic        flt_ecc2 = 1'b0;
    logic        flt_par_bkp = 1'b0;
    logic        brk_out;
    logic        pvd_cfg_lock;

    always #(CLK_P/2) clk = ~clk;

    brk_lock_reg u_dut (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .flt_lockup   (flt_lockup),
        .flt_par_main (flt_par_main),
        .flt_supply   (flt_supply),
        .flt_ecc2     (flt_ecc2),
        .flt_par_bkp  (flt_par_bkp),
        .brk_out      (brk_out),
        .pvd_cfg_lock (pvd_cfg_lock)
    );

    typedef struct {
        logic [31:0] rd;
        logic        brk;
        logic        pvd;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    // bench model state
    logic [4:0] m_lock = '0;
    logic       m_bkp = 1'b0;
    logic       m_main = 1'b0;
    logic       m_brk = 1'b0;

    // flt order: 0 lockup, 1 main parity, 2 supply, 3 ecc, 4 backup parity
    task automatic step(input logic r, input logic we, input logic [31:0] wd,
                        input logic [4:0] flt, input string tag);
        exp_t e;
        @(negedge clk);
        rst          = r;
        wr_en        = we;
        wr_data      = wd;
        flt_lockup   = flt[0];
        flt_par_main = flt[1];
        flt_supply   = flt[2];
        flt_ecc2     = flt[3];
        flt_par_bkp  = flt[4];
        if (r) begin
            m_brk  = 1'b0;
            m_lock = '0;
            m_bkp  = 1'b0;
            m_main = 1'b0;
        end else begin
            m_brk  = |(flt & m_lock);
            m_lock = m_lock | (we ? wd[4:0] : 5'b0);
            m_bkp  = flt[4] | (m_bkp & !(we && wd[7]));
            m_main = flt[1] | (m_main & !(we && wd[8]));
        end
        e.rd     = '0;
        e.rd[4:0] = m_lock;
        e.rd[7]  = m_bkp;
        e.rd[8]  = m_main;
        e.brk    = m_brk;
        e.pvd    = m_lock[2];
        e.tag    = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compare a quarter period after each edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (rd_data !== e.rd || brk_out !== e.brk || pvd_cfg_lock !== e.pvd) begin
                    errors++;
                    $display("FAIL %s: rd=%h brk=%b lock=%b expected rd=%h brk=%b lock=%b",
                             e.tag, rd_data, brk_out, pvd_cfg_lock, e.rd, e.brk, e.pvd);
                end
            end
        end
    end

    initial begin
        #(CLK_P*20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(1, 0, 32'h0, 5'b00000, "R1");
        step(1, 0, 32'h0, 5'b00000, "R1");
        // faults with no locks: no break; parity faults set flags
        step(0, 0, 32'h0, 5'b11111, "R4");
        step(0, 0, 32'h0, 5'b00000, "R5");
        // clear main flag only
        step(0, 1, 32'h0000_0100, 5'b00000, "R6");
        // write zeros: backup flag holds
        step(0, 1, 32'h0, 5'b00000, "R6");
        // clear backup flag while its fault is high: set wins
        step(0, 1, 32'h0000_0080, 5'b10000, "R7");
        step(0, 1, 32'h0000_0080, 5'b00000, "R6");
        // reserved bits ignored
        step(0, 1, 32'hFFFF_FE60, 5'b00000, "R8");
        // supply lock
        step(0, 1, 32'h0000_0004, 5'b00000, "R9");
        step(0, 0, 32'h0, 5'b00100, "R4");
        step(0, 0, 32'h0, 5'b00000, "R4");
        // lockup lock, then lockup fault and an unarmed ecc fault
        step(0, 1, 32'h0000_0001, 5'b00000, "R2");
        step(0, 0, 32'h0, 5'b00001, "R4");
        step(0, 0, 32'h0, 5'b01000, "R4");
        step(0, 0, 32'h0, 5'b00000, "R4");
        // zeros cannot clear locks
        step(0, 1, 32'h0000_0000, 5'b00000, "R3");
        step(0, 1, 32'hFFFF_FFFA, 5'b00000, "R3");
        // arm all, then each fault alone
        step(0, 1, 32'h0000_001F, 5'b00000, "R2");
        for (int i = 0; i < 5; i++) begin
            step(0, 0, 32'h0, 5'(1 << i), "R4");
            step(0, 0, 32'h0, 5'b00000, "R4");
        end
        step(0, 1, 32'h0000_0000, 5'b00010, "R5");
        // reset clears everything
        step(1, 0, 32'h0, 5'b00000, "R10");
        step(0, 0, 32'h0, 5'b00001, "R10");
        step(0, 0, 32'h0, 5'b00000, "R10");
        wait (exp_q.size() == 0);
        @(posedge clk);
        #(CLK_P/2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule